// File: doc/BRIEF.md
# Management Command Ping-Pong Responder

This block is the hardware side of a one-deep management command channel. Software opens the channel, writes a command verb together with a pool selector, and commits it. The verb's top bit is a phase bit. A commit counts as new only when its phase differs from the phase of the previous accepted command. On a new command the block runs a small executor against a set of per-pool buffer counters. It then posts the result into one of two result slots, chosen by the command's phase bit.

Software finds its starting phase by reading back the stored command verb. If that verb's phase bit is set, software expects results in slot 0 and uses phase 0. Otherwise it expects results in slot 1 and uses phase 1. After each command, software polls the active slot's verb until it is non-zero. It consumes the result, acknowledges it, then switches to the other slot and inverts its phase. A slot whose command has not yet completed reads a zero verb, so a stale or pending result is never mistaken for a fresh one.

Top module: `mgmt_pingpong_resp`

## Requirements
- R1: Reset state. The channel state is IDLE (code 0). Both result slot verbs read 0. The stored command verb reads {RESET_VBIT, 7'b0}, where RESET_VBIT defaults to 0.
- R2: Channel states are coded IDLE=0, OPEN=1, BUSY=2, DONE=3. A start in IDLE moves to OPEN; a start in any other state is ignored. An abort is obeyed only in OPEN and returns to IDLE. An abort wins over a commit in the same cycle, so that commit is not executed.
- R3: A commit (cmd_wr_i) is accepted only in OPEN and only when bit 7 of the verb differs from bit 7 of the stored command verb. Any other commit changes neither the state nor either result slot nor the stored verb.
- R4: The result of an accepted command goes to the slot numbered by its phase bit (verb bit 7). The other slot's verb and level stay unchanged.
- R5: The state is BUSY for exactly the two cycles after acceptance. During those cycles the target slot's verb reads 0. On the third clock edge after acceptance the state becomes DONE and the full result is visible.
- R6: Verb layout: bit 7 is the phase, bits 6:4 are the opcode and bits 3:0 are the count. For acquire (opcode 1) with count n, if 1 <= n <= pool level, the level drops by n and the result verb is {phase, 3'd1, n}. Otherwise the level is kept and the result verb is {phase, 3'd1, 4'd0}, meaning the pool could not supply the request.
- R7: For release (opcode 2) with count n, if n >= 1 and level + n <= 2^LVL_W - 1, the level rises by n and the result verb is {phase, 3'd2, n}. Otherwise the level is kept and the low field is 0.
- R8: Any other opcode, or a pool selector >= NPOOL, executes nothing. It returns the error verb {phase, 3'd7, 4'hE}.
- R9: The result slot's level field holds the selected pool's level after the operation. It is 0 for an error result.
- R10: An acknowledge in DONE returns the channel to IDLE; in other states it is ignored. The next command must carry the inverted phase and lands in the other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Open the channel for a command |
| abort_i | input | 1 | Drop an opened command |
| ack_i | input | 1 | Software has consumed the posted result |
| cmd_wr_i | input | 1 | Commit strobe for the command verb |
| cmd_verb_i | input | 8 | Command verb: phase, opcode, count |
| cmd_pool_i | input | PID_W | Pool selector sent with the commit |
| rd_slot_i | input | 1 | Result slot to read |
| rd_verb_o | output | 8 | Verb of the selected result slot |
| rd_level_o | output | LVL_W | Level field of the selected result slot |
| cmd_verb_o | output | 8 | Stored verb of the last accepted command |
| state_o | output | 2 | Channel state code |

## Verification
The bench sweeps every opcode, every count and every pool selector, including the selectors beyond NPOOL. It keeps its own pool model, so acquires drain pools to empty and releases reach the saturation limit. Each command is checked cycle by cycle.

Several wrong designs are targeted directly. A design that executes a repeated-phase commit would change state or write a slot. A design that writes the result verb before clearing it would show a non-zero verb while BUSY. A design that picks the wrong slot would disturb the other slot's snapshot. Out-of-order start, abort and acknowledge are each applied in states where they must do nothing, and the abort-versus-commit collision is covered too.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

   localparam int VERB_W = 8;
   localparam int OP_W   = 3;
   localparam int NUM_W  = 4;

   localparam logic [OP_W-1:0]  OP_ACQ   = 3'd1;
   localparam logic [OP_W-1:0]  OP_REL   = 3'd2;
   localparam logic [OP_W-1:0]  OP_ERR   = 3'd7;
   localparam logic [NUM_W-1:0] ERR_CODE = 4'hE;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OPEN = 2'd1,
      ST_BUSY = 2'd2,
      ST_DONE = 2'd3
   } chan_state_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_OPEN,
      SQ_DATA,
      SQ_VERB,
      SQ_DONE
   } seq_e;

endpackage

// File: rtl/mpr_seq.sv
module mpr_seq
   import mpr_pkg::*;
#(
   parameter bit RESET_VBIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              abort_i,
   input  logic              ack_i,
   input  logic              cmd_wr_i,
   input  logic [VERB_W-1:0] cmd_verb_i,
   output logic [1:0]        state_o,
   output logic              accept_o,
   output logic              data_we_o,
   output logic              verb_we_o,
   output logic [VERB_W-1:0] cmd_q_o
);

   seq_e              sq_q;
   logic [VERB_W-1:0] cmd_q;

   // a commit is fresh only if its phase differs from the last accepted one
   assign accept_o  = (sq_q == SQ_OPEN) && !abort_i && cmd_wr_i
                      && (cmd_verb_i[VERB_W-1] != cmd_q[VERB_W-1]);
   assign data_we_o = (sq_q == SQ_DATA);
   assign verb_we_o = (sq_q == SQ_VERB);
   assign cmd_q_o   = cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq_q  <= SQ_IDLE;
         cmd_q <= {RESET_VBIT, {(VERB_W-1){1'b0}}};
      end else begin
         unique case (sq_q)
            SQ_IDLE: if (start_i) sq_q <= SQ_OPEN;
            SQ_OPEN: begin
               if (abort_i) begin
                  sq_q <= SQ_IDLE;
               end else if (accept_o) begin
                  sq_q  <= SQ_DATA;
                  cmd_q <= cmd_verb_i;
               end
            end
            SQ_DATA: sq_q <= SQ_VERB;
            SQ_VERB: sq_q <= SQ_DONE;
            SQ_DONE: if (ack_i) sq_q <= SQ_IDLE;
            default: sq_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      unique case (sq_q)
         SQ_OPEN:          state_o = ST_OPEN;
         SQ_DATA, SQ_VERB: state_o = ST_BUSY;
         SQ_DONE:          state_o = ST_DONE;
         default:          state_o = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/mpr_pool_exec.sv
module mpr_pool_exec
   import mpr_pkg::*;
#(
   parameter int NPOOL     = 5,
   parameter int PID_W     = 3,
   parameter int LVL_W     = 5,
   parameter int POOL_INIT = 8,
   parameter bit REL_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              exec_en_i,
   input  logic [VERB_W-1:0] verb_i,
   input  logic [PID_W-1:0]  pid_i,
   output logic [VERB_W-1:0] res_verb_o,
   output logic [LVL_W-1:0]  res_level_o
);

   localparam logic [LVL_W:0]   LVL_MAX = {1'b0, {LVL_W{1'b1}}};
   localparam logic [PID_W:0]   NPOOL_V = (PID_W+1)'(NPOOL);

   logic [LVL_W-1:0] lvl_q [NPOOL];
   logic [LVL_W-1:0] cur;
   logic [LVL_W-1:0] new_lvl;
   logic             upd;
   logic             pid_ok;
   logic             acq_fit;
   logic             rel_fit;
   logic             rel_known;
   logic [LVL_W:0]   sum_w;
   logic [OP_W-1:0]  op;
   logic [NUM_W-1:0] num;
   logic [LVL_W-1:0] num_ext;
   logic             ph;

   assign ph      = verb_i[VERB_W-1];
   assign op      = verb_i[VERB_W-2 -: OP_W];
   assign num     = verb_i[NUM_W-1:0];
   assign num_ext = LVL_W'(num);
   assign pid_ok  = ({1'b0, pid_i} < NPOOL_V);

   always_comb begin
      cur = '0;
      for (int i = 0; i < NPOOL; i++)
         if (pid_i == PID_W'(i)) cur = lvl_q[i];
   end

   assign acq_fit = (num != '0) && (num_ext <= cur);
   assign sum_w   = {1'b0, cur} + {1'b0, num_ext};

   generate
      if (REL_EN) begin : g_rel
         assign rel_known = 1'b1;
         assign rel_fit   = (num != '0) && (sum_w <= LVL_MAX);
      end else begin : g_norel
         assign rel_known = 1'b0;
         assign rel_fit   = 1'b0;
      end
   endgenerate

   always_comb begin
      upd         = 1'b0;
      new_lvl     = cur;
      res_verb_o  = {ph, OP_ERR, ERR_CODE};
      res_level_o = '0;
      if (pid_ok && op == OP_ACQ) begin
         if (acq_fit) begin
            upd        = 1'b1;
            new_lvl    = cur - num_ext;
            res_verb_o = {ph, OP_ACQ, num};
         end else begin
            res_verb_o = {ph, OP_ACQ, {NUM_W{1'b0}}};
         end
         res_level_o = new_lvl;
      end else if (pid_ok && rel_known && op == OP_REL) begin
         if (rel_fit) begin
            upd        = 1'b1;
            new_lvl    = sum_w[LVL_W-1:0];
            res_verb_o = {ph, OP_REL, num};
         end else begin
            res_verb_o = {ph, OP_REL, {NUM_W{1'b0}}};
         end
         res_level_o = new_lvl;
      end
   end

   generate
      for (genvar g = 0; g < NPOOL; g++) begin : g_pool
         always_ff @(posedge clk) begin
            if (!rst_n)
               lvl_q[g] <= LVL_W'(POOL_INIT);
            else if (exec_en_i && upd && pid_i == PID_W'(g))
               lvl_q[g] <= new_lvl;
         end
      end
   endgenerate

endmodule

// File: rtl/mpr_result_bank.sv
module mpr_result_bank
   import mpr_pkg::*;
#(
   parameter int LVL_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_we_i,
   input  logic              data_we_i,
   input  logic              verb_we_i,
   input  logic              sel_i,
   input  logic [VERB_W-1:0] res_verb_i,
   input  logic [LVL_W-1:0]  res_level_i,
   input  logic              rd_slot_i,
   output logic [VERB_W-1:0] rd_verb_o,
   output logic [LVL_W-1:0]  rd_level_o,
   output logic [VERB_W-1:0] slot0_verb_o,
   output logic [VERB_W-1:0] slot1_verb_o
);

   localparam int NSLOT = 2;

   logic [VERB_W-1:0] verb_q [NSLOT];
   logic [LVL_W-1:0]  lvl_q  [NSLOT];
   logic [VERB_W-1:0] pend_q;

   // verb is held back one cycle so it lands after the body
   always_ff @(posedge clk) begin
      if (!rst_n)         pend_q <= '0;
      else if (data_we_i) pend_q <= res_verb_i;
   end

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               verb_q[g] <= '0;
               lvl_q[g]  <= '0;
            end else if (sel_i == 1'(g)) begin
               if (clr_we_i)  verb_q[g] <= '0;
               if (data_we_i) lvl_q[g]  <= res_level_i;
               if (verb_we_i) verb_q[g] <= pend_q;
            end
         end
      end
   endgenerate

   assign rd_verb_o    = verb_q[rd_slot_i];
   assign rd_level_o   = lvl_q[rd_slot_i];
   assign slot0_verb_o = verb_q[0];
   assign slot1_verb_o = verb_q[1];

endmodule

// File: rtl/mgmt_pingpong_resp.sv
module mgmt_pingpong_resp
   import mpr_pkg::*;
#(
   parameter int NPOOL      = 5,
   parameter int PID_W      = 3,
   parameter int LVL_W      = 5,
   parameter int POOL_INIT  = 8,
   parameter bit REL_EN     = 1'b1,
   parameter bit RESET_VBIT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic             ack_i,
   input  logic             cmd_wr_i,
   input  logic [7:0]       cmd_verb_i,
   input  logic [PID_W-1:0] cmd_pool_i,
   input  logic             rd_slot_i,
   output logic [7:0]       rd_verb_o,
   output logic [LVL_W-1:0] rd_level_o,
   output logic [7:0]       cmd_verb_o,
   output logic [1:0]       state_o
);

   generate
      if (NPOOL < 1 || NPOOL > (1 << PID_W)) begin : g_bad_npool
         $error("NPOOL must lie in 1 .. 2**PID_W");
      end
      if (LVL_W < NUM_W) begin : g_bad_lvl
         $error("LVL_W must cover the count field");
      end
      if (POOL_INIT < 0 || POOL_INIT >= (1 << LVL_W)) begin : g_bad_init
         $error("POOL_INIT does not fit in LVL_W bits");
      end
   endgenerate

   logic              accept;
   logic              data_we;
   logic              verb_we;
   logic [VERB_W-1:0] cmd_q;
   logic [PID_W-1:0]  pid_q;
   logic              slot_sel;
   logic [VERB_W-1:0] res_verb;
   logic [LVL_W-1:0]  res_level;
   logic [VERB_W-1:0] slot0_verb;
   logic [VERB_W-1:0] slot1_verb;

   mpr_seq #(.RESET_VBIT(RESET_VBIT)) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .abort_i    (abort_i),
      .ack_i      (ack_i),
      .cmd_wr_i   (cmd_wr_i),
      .cmd_verb_i (cmd_verb_i),
      .state_o    (state_o),
      .accept_o   (accept),
      .data_we_o  (data_we),
      .verb_we_o  (verb_we),
      .cmd_q_o    (cmd_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      pid_q <= '0;
      else if (accept) pid_q <= cmd_pool_i;
   end

   // on acceptance the incoming phase names the slot; afterwards the stored one
   assign slot_sel = accept ? cmd_verb_i[VERB_W-1] : cmd_q[VERB_W-1];

   mpr_pool_exec #(
      .NPOOL     (NPOOL),
      .PID_W     (PID_W),
      .LVL_W     (LVL_W),
      .POOL_INIT (POOL_INIT),
      .REL_EN    (REL_EN)
   ) exec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .exec_en_i   (data_we),
      .verb_i      (cmd_q),
      .pid_i       (pid_q),
      .res_verb_o  (res_verb),
      .res_level_o (res_level)
   );

   mpr_result_bank #(.LVL_W(LVL_W)) bank_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_we_i     (accept),
      .data_we_i    (data_we),
      .verb_we_i    (verb_we),
      .sel_i        (slot_sel),
      .res_verb_i   (res_verb),
      .res_level_i  (res_level),
      .rd_slot_i    (rd_slot_i),
      .rd_verb_o    (rd_verb_o),
      .rd_level_o   (rd_level_o),
      .slot0_verb_o (slot0_verb),
      .slot1_verb_o (slot1_verb)
   );

   assign cmd_verb_o = cmd_q;

endmodule

// File: rtl/mpr_resp_chk.sv
module mpr_resp_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_i,
   input logic       abort_i,
   input logic       ack_i,
   input logic       cmd_wr_i,
   input logic [7:0] cmd_verb_i,
   input logic [1:0] state_o,
   input logic [7:0] cmd_verb_o,
   input logic [7:0] slot0_verb,
   input logic [7:0] slot1_verb
);

   logic fresh;
   assign fresh = (state_o == 2'd1) && !abort_i && cmd_wr_i
                  && (cmd_verb_i[7] != cmd_verb_o[7]);

   a_r2_start_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd0 && start_i) |=> (state_o == 2'd1));

   a_r2_abort_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && abort_i) |=> (state_o == 2'd0));

   a_r3_same_phase_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd1 && !abort_i && cmd_wr_i && cmd_verb_i[7] == cmd_verb_o[7])
      |=> (state_o == 2'd1 && $stable(cmd_verb_o) && $stable(slot0_verb)
           && $stable(slot1_verb)));

   a_r4_slot0_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh && cmd_verb_i[7]) |=> $stable(slot0_verb));

   a_r4_slot1_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (fresh && !cmd_verb_i[7]) |=> $stable(slot1_verb));

   a_r5_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd2) |-> ((cmd_verb_o[7] ? slot1_verb : slot0_verb) == 8'd0));

   a_r5_done_posted: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3) |-> ((cmd_verb_o[7] ? slot1_verb : slot0_verb) != 8'd0));

   a_r10_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 2'd3 && ack_i) |=> (state_o == 2'd0));

endmodule

bind mgmt_pingpong_resp mpr_resp_chk chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .abort_i    (abort_i),
   .ack_i      (ack_i),
   .cmd_wr_i   (cmd_wr_i),
   .cmd_verb_i (cmd_verb_i),
   .state_o    (state_o),
   .cmd_verb_o (cmd_verb_o),
   .slot0_verb (slot0_verb),
   .slot1_verb (slot1_verb)
);

// File: tb/mgmt_pingpong_resp_tb_top.sv
module mgmt_pingpong_resp_tb_top;

   localparam int NPOOL = 5;
   localparam int PID_W = 3;
   localparam int LVL_W = 5;
   localparam int INIT  = 8;
   localparam int LMAX  = 31;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             start_i, abort_i, ack_i, cmd_wr_i, rd_slot_i;
   logic [7:0]       cmd_verb_i;
   logic [PID_W-1:0] cmd_pool_i;
   logic [7:0]       rd_verb_o, cmd_verb_o;
   logic [LVL_W-1:0] rd_level_o;
   logic [1:0]       state_o;

   int  checks = 0;
   int  fails  = 0;
   int  lv [NPOOL];
   bit  ph;
   bit  finished = 1'b0;

   always #2 clk = ~clk;

   mgmt_pingpong_resp dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .ack_i(ack_i), .cmd_wr_i(cmd_wr_i), .cmd_verb_i(cmd_verb_i),
      .cmd_pool_i(cmd_pool_i), .rd_slot_i(rd_slot_i), .rd_verb_o(rd_verb_o),
      .rd_level_o(rd_level_o), .cmd_verb_o(cmd_verb_o), .state_o(state_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic peek(input bit s, output int v, output int l);
      rd_slot_i = s;
      #1;
      v = int'(rd_verb_o);
      l = int'(rd_level_o);
   endtask

   task automatic both_zero(input string req);
      int v, l;
      peek(1'b0, v, l); chk(req, v, 0);
      peek(1'b1, v, l); chk(req, v, 0);
   endtask

   task automatic run_cmd(input int op, input int n, input int pid);
      int  ov, ol, v, l, ev, el, low;
      bit  s;
      string tag;
      s = ph;
      peek(!s, ov, ol);
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R2 start opens", int'(state_o), 1);
      cmd_wr_i   = 1'b1;
      cmd_verb_i = {ph, 3'(op), 4'(n)};
      cmd_pool_i = PID_W'(pid);
      @(negedge clk); cmd_wr_i = 1'b0;
      chk("R5 busy after accept", int'(state_o), 2);
      peek(s, v, l); chk("R5 target cleared", v, 0);
      @(negedge clk);
      chk("R5 still busy", int'(state_o), 2);
      peek(s, v, l); chk("R5 verb written last", v, 0);
      @(negedge clk);
      chk("R5 done third edge", int'(state_o), 3);
      // model
      low = 0; el = 0; tag = "R8 error result";
      if (pid < NPOOL && op == 1) begin
         tag = "R6 acquire";
         if (n != 0 && n <= lv[pid]) begin lv[pid] -= n; low = n; end
         el = lv[pid];
         ev = (int'(ph) << 7) | (1 << 4) | low;
      end else if (pid < NPOOL && op == 2) begin
         tag = "R7 release";
         if (n != 0 && lv[pid] + n <= LMAX) begin lv[pid] += n; low = n; end
         el = lv[pid];
         ev = (int'(ph) << 7) | (2 << 4) | low;
      end else begin
         ev = (int'(ph) << 7) | (7 << 4) | 14;
      end
      peek(s, v, l);
      chk(tag, v, ev);
      chk("R9 level field", l, el);
      peek(!s, v, l);
      chk("R4 other slot verb kept", v, ov);
      chk("R4 other slot level kept", l, ol);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      chk("R2 start ignored in done", int'(state_o), 3);
      ack_i = 1'b1;
      @(negedge clk); ack_i = 1'b0;
      chk("R10 ack closes", int'(state_o), 0);
      ph = ~ph;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL R5 watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, l;
      rst_n = 1'b0; start_i = 0; abort_i = 0; ack_i = 0; cmd_wr_i = 0;
      cmd_verb_i = '0; cmd_pool_i = '0; rd_slot_i = 0;
      for (int i = 0; i < NPOOL; i++) lv[i] = INIT;
      repeat (3) @(negedge clk);
      chk("R1 reset state", int'(state_o), 0);
      chk("R1 reset cmd verb", int'(cmd_verb_o), 0);
      both_zero("R1 reset slots");
      rst_n = 1'b1;
      @(negedge clk);
      ph = cmd_verb_o[7] ? 1'b0 : 1'b1;
      chk("R1 start phase", int'(ph), 1);

      // out-of-order controls
      abort_i = 1; @(negedge clk); abort_i = 0;
      chk("R2 abort ignored idle", int'(state_o), 0);
      cmd_wr_i = 1; cmd_verb_i = {ph, 3'd1, 4'd1}; cmd_pool_i = 0;
      @(negedge clk); cmd_wr_i = 0;
      chk("R3 commit ignored idle", int'(state_o), 0);
      both_zero("R3 idle commit no slot");
      ack_i = 1; @(negedge clk); ack_i = 0;
      chk("R10 ack ignored idle", int'(state_o), 0);
      start_i = 1; @(negedge clk); start_i = 0;
      chk("R2 start opens", int'(state_o), 1);
      ack_i = 1; @(negedge clk); ack_i = 0;
      chk("R10 ack ignored open", int'(state_o), 1);
      abort_i = 1; @(negedge clk); abort_i = 0;
      chk("R2 abort closes", int'(state_o), 0);
      start_i = 1; @(negedge clk); start_i = 0;
      cmd_wr_i = 1; cmd_verb_i = {~ph, 3'd1, 4'd2};
      @(negedge clk); cmd_wr_i = 0;
      chk("R3 same phase ignored", int'(state_o), 1);
      chk("R3 cmd verb kept", int'(cmd_verb_o), 0);
      both_zero("R3 same phase no slot");
      abort_i = 1; cmd_wr_i = 1; cmd_verb_i = {ph, 3'd1, 4'd2};
      @(negedge clk); abort_i = 0; cmd_wr_i = 0;
      chk("R2 abort wins", int'(state_o), 0);
      repeat (3) @(negedge clk);
      both_zero("R2 aborted not run");
      peek(1'b0, v, l);

      // near-exhaustive sweep
      for (int p = 0; p < 8; p++)
         for (int o = 0; o < 8; o++)
            for (int n = 0; n < 16; n++)
               run_cmd(o, n, p);

      // drive pool 0 to saturation and empty
      for (int k = 0; k < 4; k++) run_cmd(2, 15, 0);
      for (int k = 0; k < 6; k++) run_cmd(1, 8, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule